// File: doc/BRIEF.md
# Receive Mailbox with Data Interrupt

This block is a receive mailbox that a host processor reads over a 32-bit register interface. A producer inside the chip hands words over through a valid/ready push port. The words wait in a small ordered store. The host can pop the oldest word, look at it without removing it, read a status word, and read or write a config word. A single interrupt line tells the host that words are waiting. It is raised only while the host has enabled it.

The block looks only at the low 8 bits of the access address. Reads are answered one cycle after the request. Each answer reflects the state as it stood before that request. When the host pops an empty mailbox, it gets a fixed invalid marker rather than stale data. The store depth and the marker value are parameters.

Top module: `mbox_rx`

## Requirements
- R1: A word-sized read whose low address byte lies between 0x80 and 0x8C returns the oldest stored word and removes it from the mailbox.
- R2: A pop of an empty mailbox returns the invalid marker (default 32'hFFFF_FFFF) and leaves the count and the config word unchanged.
- R3: A word-sized read at low byte 0x90 returns the oldest stored word, or the marker when the mailbox is empty, and removes nothing.
- R4: A read at low byte 0x98 returns bit 31 set when the mailbox holds DEPTH words and bit 30 set when it holds none. All other bits read 0, so the two flags are never set together.
- R5: At low byte 0x9C, bit 0 is the interrupt enable and the only writable bit. Bit 4 reads 1 whenever the mailbox is not empty. All other bits read 0.
- R6: `irq_o` is high exactly when the enable bit is set and the mailbox is not empty.
- R7: Reset empties the mailbox and clears the config word, and a peek right after reset returns the marker.
- R8: Words leave in the order they arrived. Once every word has been popped, a peek returns the marker.
- R9: Only accesses with `acc_size` = 2'b10 (32-bit) take effect; any other size reads 0 and changes nothing. Reads of unmapped offsets return 0, and writes to unmapped offsets change nothing.
- R10: `rd_valid` is high and `rd_data` holds the answer in the cycle after each read request.
- R11: `push_ready` is low while the mailbox is full. A push with `push_valid` and `push_ready` both high stores the word.
- R12: The status word and `irq_o` reflect a push or a pop in the cycle right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Byte address; only the low 8 bits are decoded |
| acc_size | input | 2 | Access size code; 2'b10 = 32-bit |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read answer, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after a read request |
| push_valid | input | 1 | Producer offers a word |
| push_data | input | 32 | Word offered by the producer |
| push_ready | output | 1 | Mailbox can take a word |
| irq_o | output | 1 | Data-waiting interrupt |

## Verification
If the count drifts from the real number of stored words, the error shows up at the ports. The status flags and the interrupt are wrong in the next cycle. A pop then returns either the marker while words remain, or a stale word instead of the marker. If the shift path is corrupted, the pop order breaks or the word in the vacated slot is not the marker, and the drained-mailbox peek exposes it at once. A wrong enable bit shows on `irq_o` in the cycle after the config write.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam logic [7:0] OFF_POP_LO = 8'h80;
    localparam logic [7:0] OFF_POP_HI = 8'h8C;
    localparam logic [7:0] OFF_PEEK   = 8'h90;
    localparam logic [7:0] OFF_STAT   = 8'h98;
    localparam logic [7:0] OFF_CFG    = 8'h9C;

    localparam logic [1:0] SIZE_WORD  = 2'b10;

    localparam int STAT_FULL_BIT  = 31;
    localparam int STAT_EMPTY_BIT = 30;
    localparam int CFG_EN_BIT     = 0;
    localparam int CFG_PEND_BIT   = 4;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_POP,
        ACC_PEEK,
        ACC_STAT,
        ACC_CFG_RD,
        ACC_CFG_WR,
        ACC_IGNORE
    } acc_kind_e;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
    import mbox_pkg::*;
(
    input  logic       en,
    input  logic       wr,
    input  logic [7:0] off,
    input  logic [1:0] size,
    output acc_kind_e  kind
);
    always_comb begin
        kind = ACC_NONE;
        if (en) begin
            kind = ACC_IGNORE;
            if (size == SIZE_WORD) begin
                if (wr) begin
                    if (off == OFF_CFG) kind = ACC_CFG_WR;
                end else if (off >= OFF_POP_LO && off <= OFF_POP_HI) begin
                    kind = ACC_POP;
                end else if (off == OFF_PEEK) begin
                    kind = ACC_PEEK;
                end else if (off == OFF_STAT) begin
                    kind = ACC_STAT;
                end else if (off == OFF_CFG) begin
                    kind = ACC_CFG_RD;
                end
            end
        end
    end
endmodule

// File: rtl/mbox_slot_fifo.sv
module mbox_slot_fifo #(
    parameter int          DEPTH   = 8,
    parameter int          W       = 32,
    parameter logic [W-1:0] INVALID = '1,
    localparam int         CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t s_d, s_q;
    logic [CW-1:0] wr_idx;

    always_comb begin
        s_d    = s_q;
        wr_idx = s_q.cnt;
        if (pop && s_q.cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                s_d.slot[i] = s_q.slot[i+1];
            end
            s_d.slot[DEPTH-1] = INVALID;
            wr_idx  = s_q.cnt - 1'b1;
            s_d.cnt = wr_idx;
        end
        if (push && s_q.cnt != CW'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == wr_idx) s_d.slot[i] = push_data;
            end
            s_d.cnt = wr_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            for (int i = 0; i < DEPTH; i++) s_q.slot[i] <= INVALID;
        end else begin
            s_q <= s_d;
        end
    end

    assign head  = s_q.slot[0];
    assign count = s_q.cnt;
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign empty = (s_q.cnt == '0);
endmodule

// File: rtl/mbox_rx.sv
module mbox_rx
    import mbox_pkg::*;
#(
    parameter int          DEPTH   = 8,
    parameter int          AW      = 12,
    parameter logic [31:0] INVALID = 32'hFFFF_FFFF,
    localparam int         CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_addr,
    input  logic [1:0]    acc_size,
    input  logic [31:0]   acc_wdata,
    output logic [31:0]   rd_data,
    output logic          rd_valid,
    input  logic          push_valid,
    input  logic [31:0]   push_data,
    output logic          push_ready,
    output logic          irq_o
);
    typedef struct packed {
        logic [31:0] rdata;
        logic        rvalid;
        logic        irq_en;
    } regs_t;

    regs_t r_d, r_q;

    acc_kind_e     kind;
    logic [31:0]   fifo_head;
    logic [CW-1:0] fifo_cnt;
    logic          fifo_full;
    logic          fifo_empty;
    logic          pop_req;
    logic          pop_eff;
    logic          push_fire;
    logic          irq_en;
    logic          unused_bits;

    assign unused_bits = ^{acc_addr, acc_wdata[31:1]};

    mbox_decode u_dec (
        .en   (acc_en),
        .wr   (acc_wr),
        .off  (acc_addr[7:0]),
        .size (acc_size),
        .kind (kind)
    );

    assign pop_req    = (kind == ACC_POP);
    assign pop_eff    = pop_req && !fifo_empty;
    assign push_ready = !fifo_full;
    assign push_fire  = push_valid && push_ready;

    mbox_slot_fifo #(
        .DEPTH   (DEPTH),
        .W       (32),
        .INVALID (INVALID)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_fire),
        .push_data (push_data),
        .pop       (pop_eff),
        .head      (fifo_head),
        .count     (fifo_cnt),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = acc_en && !acc_wr;
        r_d.rdata  = '0;
        unique case (kind)
            ACC_POP:    r_d.rdata = fifo_empty ? INVALID : fifo_head;
            ACC_PEEK:   r_d.rdata = fifo_head;
            ACC_STAT: begin
                r_d.rdata[STAT_FULL_BIT]  = fifo_full;
                r_d.rdata[STAT_EMPTY_BIT] = fifo_empty;
            end
            ACC_CFG_RD: begin
                r_d.rdata[CFG_EN_BIT]   = r_q.irq_en;
                r_d.rdata[CFG_PEND_BIT] = !fifo_empty;
            end
            ACC_CFG_WR: r_d.irq_en = acc_wdata[CFG_EN_BIT];
            default:    r_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq_en   = r_q.irq_en;
    assign rd_data  = r_q.rdata;
    assign rd_valid = r_q.rvalid;
    assign irq_o    = r_q.irq_en && !fifo_empty;
endmodule

// File: rtl/mbox_rx_chk.sv
module mbox_rx_chk #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          full,
    input logic          empty,
    input logic [CW-1:0] cnt,
    input logic          pop_req,
    input logic          pop_eff,
    input logic          push_fire,
    input logic          push_ready,
    input logic          irq_en,
    input logic          irq_o,
    input logic          acc_en,
    input logic          acc_wr,
    input logic          rd_valid
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({full, empty})); // R4

    AST_READY_LOW_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push_ready); // R11

    AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push_fire) |=> (cnt == '0)); // R2

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_eff && !push_fire) |=> (cnt == $past(cnt) - 1'b1)); // R1

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_fire && !pop_eff) |=> (cnt == $past(cnt) + 1'b1)); // R12

    AST_LAST_POP_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_eff && cnt == 1 && !push_fire) |=> !irq_o); // R6

    AST_PUSH_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (push_fire && irq_en && !(acc_en && acc_wr)) |=> irq_o); // R6

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr) |=> rd_valid); // R10
endmodule

bind mbox_rx mbox_rx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .full       (fifo_full),
    .empty      (fifo_empty),
    .cnt        (fifo_cnt),
    .pop_req    (pop_req),
    .pop_eff    (pop_eff),
    .push_fire  (push_fire),
    .push_ready (push_ready),
    .irq_en     (irq_en),
    .irq_o      (irq_o),
    .acc_en     (acc_en),
    .acc_wr     (acc_wr),
    .rd_valid   (rd_valid)
);

// File: tb/sim_mbox_rx.sv
module sim_mbox_rx;
    localparam int          DEPTH = 8;
    localparam int          AW    = 12;
    localparam logic [31:0] INV   = 32'hFFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_en = 1'b0;
    logic          acc_wr = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [1:0]    acc_size = 2'b10;
    logic [31:0]   acc_wdata = '0;
    logic [31:0]   rd_data;
    logic          rd_valid;
    logic          push_valid = 1'b0;
    logic [31:0]   push_data = '0;
    logic          push_ready;
    logic          irq_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    logic [31:0] q[$];
    bit  m_en = 1'b0;

    always #5 clk = ~clk;

    mbox_rx #(.DEPTH(DEPTH), .AW(AW), .INVALID(INV)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .push_valid(push_valid),
        .push_data(push_data), .push_ready(push_ready), .irq_o(irq_o)
    );

    function automatic logic [31:0] exp_status(int n);
        logic [31:0] v = '0;
        if (n == 0) v[30] = 1'b1;
        if (n == DEPTH) v[31] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] exp_config(bit en, int n);
        logic [31:0] v = '0;
        v[0] = en;
        v[4] = (n != 0);
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus(input bit wr, input logic [AW-1:0] a, input logic [31:0] wd,
                       input logic [1:0] sz, output logic [31:0] rd);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = wd; acc_size = sz;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
        rd = rd_data;
        if (!wr) chk("R10 rd_valid", {31'b0, rd_valid}, 32'd1);
    endtask

    task automatic push(input logic [31:0] d);
        bit acc;
        @(negedge clk);
        chk("R11 push_ready", {31'b0, push_ready}, {31'b0, q.size() < DEPTH});
        acc = push_ready;
        push_valid = 1'b1; push_data = d;
        @(negedge clk);
        push_valid = 1'b0;
        if (acc) q.push_back(d);
        chk("R12 irq after push", {31'b0, irq_o}, {31'b0, m_en && q.size() != 0});
    endtask

    task automatic do_pop(input string req);
        logic [31:0] r, e;
        e = (q.size() != 0) ? q.pop_front() : INV;
        bus(1'b0, 12'h380 + 12'(4 * ($urandom % 4)), '0, 2'b10, r);
        chk(req, r, e);
        chk("R12 irq after pop", {31'b0, irq_o}, {31'b0, m_en && q.size() != 0});
    endtask

    task automatic do_peek(input string req);
        logic [31:0] r;
        bus(1'b0, 12'h090, '0, 2'b10, r);
        chk(req, r, (q.size() != 0) ? q[0] : INV);
    endtask

    task automatic do_stat(input string req);
        logic [31:0] r;
        bus(1'b0, 12'h798, '0, 2'b10, r);
        chk(req, r, exp_status(q.size()));
    endtask

    task automatic do_cfg(input string req);
        logic [31:0] r;
        bus(1'b0, 12'h09C, '0, 2'b10, r);
        chk(req, r, exp_config(m_en, q.size()));
    endtask

    task automatic set_en(input logic [31:0] v);
        logic [31:0] r;
        bus(1'b1, 12'h09C, v, 2'b10, r);
        m_en = v[0];
        chk("R6 irq follows enable", {31'b0, irq_o}, {31'b0, m_en && q.size() != 0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        process::self().srandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk("R7 irq after reset", {31'b0, irq_o}, 32'd0);
        do_stat("R7 status after reset");
        do_cfg("R7 config after reset");
        do_peek("R7 peek after reset");
        // R2 pop empty
        do_pop("R2 pop of empty mailbox");
        do_cfg("R2 config unchanged");
        // R9 unmapped and non-word
        bus(1'b0, 12'h0A0, '0, 2'b10, r); chk("R9 unmapped read", r, 32'd0);
        bus(1'b1, 12'h0A0, 32'h1, 2'b10, r);
        bus(1'b1, 12'h09C, 32'h1, 2'b01, r);
        do_cfg("R9 stray writes ignored");
        // R6 enable then data
        set_en(32'hFFFF_FFFF);
        do_cfg("R5 only bit 0 writable");
        for (int i = 0; i < DEPTH + 2; i++) push(32'h1000 + i);
        do_stat("R4 full flag");
        do_cfg("R5 pending with data");
        bus(1'b0, 12'h080, '0, 2'b00, r); chk("R9 byte read returns 0", r, 32'd0);
        do_peek("R9 byte pop removed nothing");
        do_peek("R3 peek does not pop");
        do_stat("R3 still full");
        set_en(32'h0);
        set_en(32'h1);
        for (int i = 0; i < DEPTH; i++) do_pop("R8 pop order");
        do_peek("R8 drained head is marker");
        do_stat("R4 empty flag");
        // mid-run reset
        push(32'hABCD_0001); push(32'hABCD_0002);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        q.delete(); m_en = 1'b0;
        @(negedge clk);
        chk("R7 irq after mid reset", {31'b0, irq_o}, 32'd0);
        do_peek("R7 peek after mid reset");
        do_cfg("R7 config after mid reset");
        // random mix
        for (int k = 0; k < 600; k++) begin
            int op = $urandom % 10;
            if (op < 4)       push($urandom);
            else if (op < 7)  do_pop("R1 random pop");
            else if (op == 7) do_peek("R3 random peek");
            else if (op == 8) do_stat("R4 random status");
            else begin
                if ($urandom % 2) set_en($urandom);
                else do_cfg("R5 random config");
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule